// File: doc/BRIEF.md
# Triggered Conversion Queue Sequencer

This block walks a table of conversion command words and asks an attached converter for one conversion per entry. Each scan is a single pass. It always starts at table entry 0 and ends at an end-of-queue marker, or after the last table slot has been converted. Software arms a scan by pulsing `scan_en_set`. The sequencer drops the scan-enable bit itself when the scan ends.

Two trigger sources are supported, chosen by `mode`.

In gated mode (`mode`=0), a high level on `gate_in` lets an armed scan start. The sequencer looks at the gate again only when each conversion reports done. If the gate is low at that moment, the scan stops. Scan-enable is cleared, the abort flag is set, and `last_ptr` holds the index of the last entry that was converted.

In timer mode (`mode`=1), an interval counter starts running as soon as the scan is armed. When the selected power-of-two period has elapsed, the counter fires an internal trigger that starts the scan. In this mode the gate has no effect.

The completion and abort flags are sticky. Each is cleared by its own clear pulse.

Top module: `conv_queue_seq`

## Requirements
- R1: After reset, `scan_en`, `done_flag`, `abort_flag`, `conv_start` and `tbl_rd` are 0, and `last_ptr` is 0.
- R2: In gated mode a scan starts only while `scan_en` is 1 and `gate_in` is high. A high gate with scan-enable clear, or an armed scan with a low gate, issues no conversion. `conv_start` is never high while `scan_en` is 0.
- R3: A scan reads entries from index 0 upward. For each entry, `conv_start` pulses for one cycle with `conv_chan` equal to bits [CHW-1:0] of the command word. A channel code of all ones (31 with CHW=5) is the end-of-queue marker: it ends the scan without a conversion. At the end of the scan `scan_en` clears, and `done_flag` sets on the following cycle.
- R4: If no marker is present, the scan ends normally after the entry at index DEPTH-1 has been converted.
- R5: Bit CHW of a command word is a pause marker. It has no effect: the conversion is issued, the scan continues, and `abort_flag` stays 0.
- R6: In gated mode the gate is sampled in the cycle `conv_done` is high. A low gate at that point ends the scan and clears `scan_en`. It sets `abort_flag` and not `done_flag`, and `last_ptr` holds the index of the entry just converted. This check takes priority over the end at the last slot.
- R7: A low pulse on `gate_in` that starts and ends within a conversion, before `conv_done`, is not seen, and the scan completes.
- R8: After a scan ends, no new scan starts, even with the gate held high, until `scan_en_set` is pulsed again. The next scan restarts at entry 0.
- R9: In timer mode, with `period_sel`=k for k from 0 to 10, the first conversion follows the arming pulse after 2^(7+k) cycles plus a fixed latency of a few cycles. The scan then runs to its end whatever the level of `gate_in`.
- R10: In timer mode, a `period_sel` value above 10 stops the timer, so an armed scan never starts.
- R11: `done_flag` and `abort_flag` stay set until their own clear input (`clr_done` or `clr_abort`) is pulsed. Clearing one flag leaves the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_en_set | input | 1 | Pulse that arms a single scan |
| clr_done | input | 1 | Pulse that clears the completion flag |
| clr_abort | input | 1 | Pulse that clears the abort flag |
| mode | input | 1 | Trigger source: 0 gated, 1 interval timer |
| period_sel | input | SEL_W | Timer exponent select: period is 2^(7+value); values above 10 stop the timer |
| gate_in | input | 1 | External gate; high means open |
| tbl_rd | output | 1 | Command table read strobe |
| tbl_addr | output | AW | Command table read address |
| tbl_data | input | CHW+1 | Command word, valid one cycle after `tbl_rd` |
| conv_start | output | 1 | One-cycle conversion request |
| conv_chan | output | CHW | Channel for the requested conversion |
| conv_done | input | 1 | Converter reports the conversion is finished |
| scan_en | output | 1 | Scan-enable bit |
| done_flag | output | 1 | Sticky normal-completion flag |
| abort_flag | output | 1 | Sticky gate-abort flag |
| last_ptr | output | AW | Index of the last completed conversion |

## Verification
The gated scan is run over several table shapes: a marker early, a marker at entry 1, a marker at entry 0, and no marker at all. Comparing these separates an end caused by the marker from an end caused by the last slot. Gate closures are placed in mid-table, during the conversion just before a marker, and during the last slot. Together they show that the gate is sampled at the conversion boundary and that this sample outranks the end-of-queue check. A short gate glitch inside a conversion shows that the gate is not sampled at other times. Timer runs at two periods, plus one with a stopped select value, show the power-of-two scaling and that the timer obeys the arming bit.

// File: rtl/cqs_pkg.sv
package cqs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FETCH  = 2'd1,
    ST_DECODE = 2'd2,
    ST_CONV   = 2'd3
  } seq_state_t;

  localparam logic MODE_GATED = 1'b0;
  localparam logic MODE_TIMER = 1'b1;

endpackage

// File: rtl/cqs_interval_timer.sv
module cqs_interval_timer #(
  parameter int MIN_EXP = 7,
  parameter int NUM_SEL = 11,
  parameter int SEL_W   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] period_sel,
  output logic             fire
);

  localparam int CNT_W = MIN_EXP + NUM_SEL - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   lim_full;
  logic [CNT_W:0]   lim_m1;
  logic             sel_ok;
  int               shamt;

  always_comb begin
    sel_ok   = (int'(period_sel) < NUM_SEL);
    shamt    = int'(period_sel) + MIN_EXP;
    lim_full = {{CNT_W{1'b0}}, 1'b1} << shamt;
    lim_m1   = lim_full - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !run || !sel_ok) begin
      cnt  <= '0;
      fire <= 1'b0;
    end else if ({1'b0, cnt} == lim_m1) begin
      cnt  <= '0;
      fire <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      fire <= 1'b0;
    end
  end

endmodule

// File: rtl/cqs_sticky_flags.sv
module cqs_sticky_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_p,
  input  logic [N-1:0] clr_p,
  output logic [N-1:0] q
);

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)
        q[i] <= 1'b0;
      else if (set_p[i])
        q[i] <= 1'b1;
      else if (clr_p[i])
        q[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/cqs_scan_engine.sv
module cqs_scan_engine
  import cqs_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CHW   = 5,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           scan_en_set,
  input  logic           mode,
  input  logic           gate_in,
  input  logic           timer_fire,
  output logic           timer_run,
  output logic           tbl_rd,
  output logic [AW-1:0]  tbl_addr,
  input  logic [CHW:0]   tbl_data,
  output logic           conv_start,
  output logic [CHW-1:0] conv_chan,
  input  logic           conv_done,
  output logic           scan_en,
  output logic           set_done,
  output logic           set_abort,
  output logic [AW-1:0]  last_ptr
);

  localparam logic [CHW-1:0] EOQ_CODE = {CHW{1'b1}};
  localparam logic [AW-1:0]  LAST_IDX = AW'(DEPTH - 1);

  seq_state_t     state;
  logic [AW-1:0]  ptr;
  logic           start_ok;
  logic [CHW-1:0] word_chan;
  logic           unused_pause_bit;

  assign word_chan        = tbl_data[CHW-1:0];
  assign unused_pause_bit = tbl_data[CHW];

  assign start_ok  = (mode == MODE_GATED) ? gate_in : timer_fire;
  assign timer_run = (state == ST_IDLE) && scan_en && (mode == MODE_TIMER);
  assign tbl_rd    = (state == ST_FETCH);
  assign tbl_addr  = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      ptr        <= '0;
      scan_en    <= 1'b0;
      conv_start <= 1'b0;
      conv_chan  <= '0;
      set_done   <= 1'b0;
      set_abort  <= 1'b0;
      last_ptr   <= '0;
    end else begin
      conv_start <= 1'b0;
      set_done   <= 1'b0;
      set_abort  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (!scan_en) begin
            if (scan_en_set) scan_en <= 1'b1;
          end else if (start_ok) begin
            ptr   <= '0;
            state <= ST_FETCH;
          end
        end
        ST_FETCH: state <= ST_DECODE;
        ST_DECODE: begin
          if (word_chan == EOQ_CODE) begin
            set_done <= 1'b1;
            scan_en  <= 1'b0;
            state    <= ST_IDLE;
          end else begin
            conv_start <= 1'b1;
            conv_chan  <= word_chan;
            state      <= ST_CONV;
          end
        end
        ST_CONV: begin
          if (conv_done) begin
            last_ptr <= ptr;
            if (mode == MODE_GATED && !gate_in) begin
              set_abort <= 1'b1;
              scan_en   <= 1'b0;
              state     <= ST_IDLE;
            end else if (ptr == LAST_IDX) begin
              set_done <= 1'b1;
              scan_en  <= 1'b0;
              state    <= ST_IDLE;
            end else begin
              ptr   <= ptr + 1'b1;
              state <= ST_FETCH;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/conv_queue_seq.sv
module conv_queue_seq #(
  parameter int DEPTH   = 16,
  parameter int CHW     = 5,
  parameter int SEL_W   = 4,
  parameter int MIN_EXP = 7,
  parameter int NUM_SEL = 11,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scan_en_set,
  input  logic             clr_done,
  input  logic             clr_abort,
  input  logic             mode,
  input  logic [SEL_W-1:0] period_sel,
  input  logic             gate_in,
  output logic             tbl_rd,
  output logic [AW-1:0]    tbl_addr,
  input  logic [CHW:0]     tbl_data,
  output logic             conv_start,
  output logic [CHW-1:0]   conv_chan,
  input  logic             conv_done,
  output logic             scan_en,
  output logic             done_flag,
  output logic             abort_flag,
  output logic [AW-1:0]    last_ptr
);

  logic       timer_run;
  logic       timer_fire;
  logic       set_done;
  logic       set_abort;
  logic [1:0] flags_q;

  cqs_interval_timer #(
    .MIN_EXP(MIN_EXP),
    .NUM_SEL(NUM_SEL),
    .SEL_W  (SEL_W)
  ) timer_i (
    .clk       (clk),
    .rst       (rst),
    .run       (timer_run),
    .period_sel(period_sel),
    .fire      (timer_fire)
  );

  cqs_scan_engine #(
    .DEPTH(DEPTH),
    .CHW  (CHW),
    .AW   (AW)
  ) engine_i (
    .clk        (clk),
    .rst        (rst),
    .scan_en_set(scan_en_set),
    .mode       (mode),
    .gate_in    (gate_in),
    .timer_fire (timer_fire),
    .timer_run  (timer_run),
    .tbl_rd     (tbl_rd),
    .tbl_addr   (tbl_addr),
    .tbl_data   (tbl_data),
    .conv_start (conv_start),
    .conv_chan  (conv_chan),
    .conv_done  (conv_done),
    .scan_en    (scan_en),
    .set_done   (set_done),
    .set_abort  (set_abort),
    .last_ptr   (last_ptr)
  );

  cqs_sticky_flags #(.N(2)) flags_i (
    .clk  (clk),
    .rst  (rst),
    .set_p({set_abort, set_done}),
    .clr_p({clr_abort, clr_done}),
    .q    (flags_q)
  );

  assign done_flag  = flags_q[0];
  assign abort_flag = flags_q[1];

endmodule

// File: rtl/cqs_checker.sv
module cqs_checker (
  input logic clk,
  input logic rst,
  input logic mode,
  input logic gate_in,
  input logic conv_start,
  input logic conv_done,
  input logic scan_en,
  input logic done_flag,
  input logic abort_flag,
  input logic clr_done,
  input logic clr_abort
);

  // R3
  conv_start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);

  // R2
  conv_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> scan_en);

  // R3
  done_after_en_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_flag) |-> (!$past(scan_en) && $past(scan_en, 2)));

  // R6
  abort_on_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(abort_flag) |-> ($past(conv_done, 2) && !$past(gate_in, 2) && !$past(mode, 2)));

  // R11
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (done_flag && !clr_done) |=> done_flag);

  // R11
  abort_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (abort_flag && !clr_abort) |=> abort_flag);

endmodule

bind conv_queue_seq cqs_checker chk_i (.*);

// File: tb/conv_queue_seq_tb_top.sv
module conv_queue_seq_tb_top;

  localparam int DEPTH = 16;
  localparam int CHW   = 5;
  localparam int AW    = 4;
  localparam int LAT   = 3;

  typedef struct packed {
    logic [4:0] eoq;
    logic [4:0] close_at;
    logic [4:0] exp_cnt;
    logic       exp_done;
    logic       exp_abort;
    logic [4:0] exp_last;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{5'd5,  5'd0,  5'd5,  1'b1, 1'b0, 5'd4},
    '{5'd16, 5'd0,  5'd16, 1'b1, 1'b0, 5'd15},
    '{5'd8,  5'd3,  5'd3,  1'b0, 1'b1, 5'd2},
    '{5'd3,  5'd3,  5'd3,  1'b0, 1'b1, 5'd2},
    '{5'd16, 5'd16, 5'd16, 1'b0, 1'b1, 5'd15},
    '{5'd1,  5'd0,  5'd1,  1'b1, 1'b0, 5'd0},
    '{5'd0,  5'd0,  5'd0,  1'b1, 1'b0, 5'd31}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scan_en_set = 1'b0, clr_done = 1'b0, clr_abort = 1'b0;
  logic mode = 1'b0;
  logic [3:0] period_sel = 4'd0;
  logic gate_sw = 1'b0;
  logic [4:0] close_at = 5'd0;
  logic cnt_clr = 1'b0;
  logic gate_in;
  logic tbl_rd, conv_start, conv_done, scan_en, done_flag, abort_flag;
  logic [AW-1:0] tbl_addr, last_ptr;
  logic [CHW:0] tbl_data;
  logic [CHW-1:0] conv_chan;

  logic [CHW:0] mem [DEPTH];
  logic [CHW-1:0] chan_log [32];
  logic [5:0] nconv;
  int lat_cnt;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  assign gate_in = gate_sw && (close_at == 5'd0 || nconv < {1'b0, close_at});

  conv_queue_seq dut_i (
    .clk(clk), .rst(rst), .scan_en_set(scan_en_set), .clr_done(clr_done),
    .clr_abort(clr_abort), .mode(mode), .period_sel(period_sel),
    .gate_in(gate_in), .tbl_rd(tbl_rd), .tbl_addr(tbl_addr),
    .tbl_data(tbl_data), .conv_start(conv_start), .conv_chan(conv_chan),
    .conv_done(conv_done), .scan_en(scan_en), .done_flag(done_flag),
    .abort_flag(abort_flag), .last_ptr(last_ptr)
  );

  always @(posedge clk) begin
    if (tbl_rd) tbl_data <= mem[tbl_addr];
  end

  always @(posedge clk) begin
    if (rst) begin
      lat_cnt   <= 0;
      conv_done <= 1'b0;
    end else if (conv_start) begin
      lat_cnt   <= LAT;
      conv_done <= 1'b0;
    end else begin
      conv_done <= (lat_cnt == 1);
      if (lat_cnt > 0) lat_cnt <= lat_cnt - 1;
    end
  end

  always @(posedge clk) begin
    if (cnt_clr) nconv <= 6'd0;
    else if (conv_start) begin
      chan_log[nconv[4:0]] <= conv_chan;
      nconv <= nconv + 6'd1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1;
    @(negedge clk);
    s = 1'b0;
  endtask

  task automatic fill(input int eoq);
    for (int i = 0; i < DEPTH; i++)
      mem[i] = {i[0], (i == eoq) ? 5'd31 : 5'(i + 1)};
  endtask

  task automatic wait_end(input string req);
    int n = 0;
    while (scan_en && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk({req, " scan ends"}, int'(scan_en), 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_gated(input vec_t v, input bit clr);
    string tag;
    tag = v.exp_abort ? "R6" : (v.eoq == 5'd16 ? "R4" : "R3");
    mode = 1'b0;
    gate_sw = 1'b0;
    close_at = v.close_at;
    pulse(cnt_clr);
    if (clr) begin
      clr_done = 1'b1; clr_abort = 1'b1;
      @(negedge clk);
      clr_done = 1'b0; clr_abort = 1'b0;
    end
    fill(int'(v.eoq));
    gate_sw = 1'b1;
    pulse(scan_en_set);
    @(negedge clk);
    wait_end(tag);
    chk({tag, " conversion count"}, int'(nconv), int'(v.exp_cnt));
    for (int k = 0; k < int'(v.exp_cnt); k++)
      chk("R3 channel order", int'(chan_log[k]), k + 1);
    chk({tag, " done_flag"}, int'(done_flag), int'(v.exp_done));
    chk(v.exp_abort ? "R6 abort_flag" : "R5 abort_flag with pause bits", int'(abort_flag), int'(v.exp_abort));
    if (v.exp_last != 5'd31)
      chk({tag, " last_ptr"}, int'(last_ptr), int'(v.exp_last));
    repeat (20) @(negedge clk);
    chk("R8 no restart without re-arm", int'(nconv), int'(v.exp_cnt));
    gate_sw = 1'b0;
  endtask

  task automatic timer_run(input logic [3:0] sel, input int lo, input int hi);
    int n = 0;
    mode = 1'b1;
    period_sel = sel;
    gate_sw = 1'b0;
    close_at = 5'd0;
    fill(3);
    pulse(cnt_clr);
    pulse(scan_en_set);
    n = 1;
    while (nconv == 0 && n < 2000) begin
      @(negedge clk);
      n++;
    end
    total++;
    if (n < lo || n > hi) begin
      bad++;
      $display("FAIL R9 start delay actual=%0d expected=%0d..%0d", n, lo, hi);
    end
    wait_end("R9");
    chk("R9 conversions with gate low", int'(nconv), 3);
    chk("R9 done_flag", int'(done_flag), 1);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) chan_log[i] = '0;
    mem[0] = '0;
    cnt_clr = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    cnt_clr = 1'b0;
    @(negedge clk);
    chk("R1 scan_en", int'(scan_en), 0);
    chk("R1 done_flag", int'(done_flag), 0);
    chk("R1 abort_flag", int'(abort_flag), 0);
    chk("R1 conv_start", int'(conv_start), 0);
    chk("R1 tbl_rd", int'(tbl_rd), 0);
    chk("R1 last_ptr", int'(last_ptr), 0);

    fill(2);
    gate_sw = 1'b1;
    repeat (30) @(negedge clk);
    chk("R2 gate high without enable", int'(nconv), 0);
    gate_sw = 1'b0;
    pulse(scan_en_set);
    repeat (30) @(negedge clk);
    chk("R2 armed with gate low", int'(nconv), 0);
    chk("R2 still armed", int'(scan_en), 1);
    gate_sw = 1'b1;
    @(negedge clk);
    wait_end("R2");
    chk("R2 conversions after gate opens", int'(nconv), 2);
    gate_sw = 1'b0;

    foreach (VECS[i]) run_gated(VECS[i], 1'b1);

    run_gated(VECS[2], 1'b1);
    run_gated('{5'd5, 5'd0, 5'd5, 1'b1, 1'b1, 5'd4}, 1'b0);
    pulse(clr_abort);
    chk("R11 abort cleared", int'(abort_flag), 0);
    chk("R11 done kept", int'(done_flag), 1);
    pulse(clr_done);
    chk("R11 done cleared", int'(done_flag), 0);

    fill(4);
    close_at = 5'd0;
    pulse(cnt_clr);
    gate_sw = 1'b1;
    pulse(scan_en_set);
    while (nconv != 6'd2) @(negedge clk);
    gate_sw = 1'b0;
    @(negedge clk);
    gate_sw = 1'b1;
    wait_end("R7");
    chk("R7 glitch missed, count", int'(nconv), 4);
    chk("R7 abort_flag", int'(abort_flag), 0);
    chk("R7 done_flag", int'(done_flag), 1);
    gate_sw = 1'b0;
    pulse(clr_done);

    timer_run(4'd0, 128, 140);
    pulse(clr_done);
    timer_run(4'd1, 256, 268);
    pulse(clr_done);

    period_sel = 4'd11;
    fill(3);
    pulse(cnt_clr);
    pulse(scan_en_set);
    repeat (400) @(negedge clk);
    chk("R10 no start with stopped timer", int'(nconv), 0);
    chk("R10 still armed", int'(scan_en), 1);
    period_sel = 4'd0;
    repeat (200) @(negedge clk);
    chk("R10 runs after valid select", int'(nconv), 3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule